// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control unit. Each cycle it looks at a pending exception code and an external interrupt request. It decides whether an event is taken. When one is taken, it performs the whole state switch into the handler on a single clock edge. The switch saves the status word, the program counter and the stack register. It then forces the status word into privileged, blocked mode on the alternate register bank, picks the handler address and records the event code.

Exceptions always win over interrupts. An exception that arrives while events are blocked is turned into a reset, with one exempt code. An interrupt is accepted only when its level is above the current mask. The saved program counter is wound back for a fault inside a branch delay slot, and moved forward for the trap instruction. Handler addresses are a fixed reset address, or the vector base plus one of three offsets.

Top module: `evt_entry_seq`

## Requirements
- R1: When `exc_valid_i` and `irq_req_i` are both high, the exception is taken. EXPEVT receives the exception code and INTEVT keeps its value.
- R2: If status bit 28 (block) is set, an exception whose code is not 0x1E0 is taken as code 0x000. Code 0x1E0 keeps its own code and handling.
- R3: If status bit 28 is set and no exception is pending, an interrupt is taken only when `halt_wait_i` is high. Otherwise nothing changes.
- R4: An interrupt is taken only when `irq_level_i` is strictly greater than the mask in status bits 7:4. An equal or lower level has no effect.
- R5: On every taken event, SSR receives `sr_i`, SGR receives `r15_i` and the new status word is `sr_i` with bits 30 (privileged), 29 (bank) and 28 (block) set.
- R6: Slot flag bit 0 marks a delay slot and bit 1 marks a conditional delay slot. When either is set on a taken event, SPC is `pc_i - 2` and all three flags are written as 0. Otherwise SPC is `pc_i` and the flags are copied.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set bits 7:4 to 0xF and branch to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 branch to `vbr_i + 0x400`. Every other exception not listed in R7 branches to `vbr_i + 0x100`.
- R9: For exception code 0x160, SPC is increased by 2 after any R6 adjustment.
- R10: A taken interrupt writes `irq_code_i` to INTEVT, leaves EXPEVT unchanged and branches to `vbr_i + 0x600`.
- R11: `taken_o` is high for the one cycle after the edge that accepted an event. When no event is accepted, every output register keeps its value.
- R12: Synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid_i | input | 1 | An exception code is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | External interrupt request |
| irq_level_i | input | 4 | Priority level of the request |
| irq_code_i | input | 12 | Event code of the request |
| halt_wait_i | input | 1 | Core is halted waiting for an interrupt |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current stack register |
| vbr_i | input | 32 | Vector base |
| slot_flags_i | input | 3 | Delay-slot flags (bit0 slot, bit1 conditional slot, bit2 condition true) |
| taken_o | output | 1 | Event accepted on the previous edge |
| pc_o | output | 32 | Handler address |
| sr_o | output | 32 | New status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack register |
| expevt_o | output | 12 | Last taken exception code |
| intevt_o | output | 12 | Last taken interrupt code |
| slot_flags_o | output | 3 | Delay-slot flags after entry |

## Verification
Every result is registered. The handler address, status words, saved copies, event codes and the strobe all become valid at the rising edge right after the cycle in which the inputs are presented. The strobe falls again one edge later if the inputs have gone idle. The bench drives stimulus on a falling edge and returns the inputs to idle on the next falling edge. In that same moment, half a cycle after the capturing edge, it compares all outputs. A second check one falling edge later confirms that the strobe dropped and that every output held through the idle cycle.

// File: rtl/evt_entry_pkg.sv
// Package: shared constants and types for the event entry sequencer.
// Assumes a 32-bit status word with fixed control-bit positions that the
// core's decoder also relies on.
package evt_entry_pkg;

    // Status word bit positions (decoded by neighbouring logic)
    localparam int SR_PRIV_BIT  = 30;
    localparam int SR_BANK_BIT  = 29;
    localparam int SR_BLOCK_BIT = 28;
    localparam int SR_FPUOFF_BIT = 15;
    localparam int SR_MASK_LSB  = 4;

    // Width of event codes
    localparam int CODE_W = 12;

    // Event codes with special handling
    localparam logic [CODE_W-1:0] C_RESET_PWR   = 12'h000;
    localparam logic [CODE_W-1:0] C_RESET_MAN   = 12'h020;
    localparam logic [CODE_W-1:0] C_MULTI_HIT   = 12'h140;
    localparam logic [CODE_W-1:0] C_MISS_READ   = 12'h040;
    localparam logic [CODE_W-1:0] C_MISS_WRITE  = 12'h060;
    localparam logic [CODE_W-1:0] C_TRAP        = 12'h160;
    localparam logic [CODE_W-1:0] C_BLOCK_EXEMPT = 12'h1E0;

    // Delay-slot flag positions
    localparam int SLOT_W        = 3;
    localparam int SLOT_PLAIN    = 0;
    localparam int SLOT_COND     = 1;

    // Which kind of event is taken this cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2
    } ev_kind_e;

endpackage

// File: rtl/evt_arbiter.sv
// Module: evt_arbiter
// Decides whether an event is taken this cycle and which code it carries.
// Exceptions always win. A blocked exception becomes the reset code
// unless it is the exempt code. An interrupt needs the block bit clear (or a
// halted core) and a level strictly above the mask.
// Assumes: purely combinational, inputs stable for the cycle.
module evt_arbiter
    import evt_entry_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic              halt_wait_i,
    input  logic              blocked_i,
    input  logic [LVL_W-1:0]  mask_i,
    output ev_kind_e          kind_o,
    output logic [CODE_W-1:0] exc_code_o
);

    logic irq_allowed;

    // Purpose: interrupt passes the block gate and the level mask
    always_comb begin
        irq_allowed = irq_req_i && (!blocked_i || halt_wait_i)
                      && (irq_level_i > mask_i);
    end

    // Purpose: select event kind and effective exception code
    always_comb begin
        kind_o     = EV_NONE;
        exc_code_o = exc_code_i;
        if (exc_valid_i) begin
            kind_o = EV_EXC;
            if (blocked_i && (exc_code_i != C_BLOCK_EXEMPT)) begin
                exc_code_o = C_RESET_PWR;
            end
        end else if (irq_allowed) begin
            kind_o = EV_IRQ;
        end
    end

endmodule

// File: rtl/evt_vector.sv
// Module: evt_vector
// Computes the handler address and the new status word for a taken event.
// Reset-class exceptions go to a fixed address with the mask raised and the
// FPU-disable bit cleared. TLB-miss codes use one offset, other exceptions
// another, and interrupts a third, each added to the vector base.
// Assumes: the mask field of width LVL_W sits at SR_MASK_LSB.
module evt_vector
    import evt_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          LVL_W      = 4,
    parameter logic [31:0] RESET_ADDR = 32'hA000_0000,
    parameter logic [31:0] OFS_EXC    = 32'h0000_0100,
    parameter logic [31:0] OFS_MISS   = 32'h0000_0400,
    parameter logic [31:0] OFS_IRQ    = 32'h0000_0600
) (
    input  ev_kind_e          kind_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [XLEN-1:0]   sr_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   sr_o
);

    localparam logic [XLEN-1:0] ENTRY_SET = (XLEN'(1) << SR_PRIV_BIT)
                                          | (XLEN'(1) << SR_BANK_BIT)
                                          | (XLEN'(1) << SR_BLOCK_BIT);

    logic is_reset_class;
    logic is_miss_class;

    // Purpose: classify the exception code
    always_comb begin
        is_reset_class = (code_i == C_RESET_PWR) || (code_i == C_RESET_MAN)
                         || (code_i == C_MULTI_HIT);
        is_miss_class  = (code_i == C_MISS_READ) || (code_i == C_MISS_WRITE);
    end

    // Purpose: handler address and new status word
    always_comb begin
        sr_o = sr_i | ENTRY_SET;
        pc_o = vbr_i + XLEN'(OFS_EXC);
        if (kind_i == EV_IRQ) begin
            pc_o = vbr_i + XLEN'(OFS_IRQ);
        end else if (is_reset_class) begin
            pc_o = XLEN'(RESET_ADDR);
            sr_o[SR_FPUOFF_BIT] = 1'b0;
            sr_o[SR_MASK_LSB +: LVL_W] = '1;
        end else if (is_miss_class) begin
            pc_o = vbr_i + XLEN'(OFS_MISS);
        end
    end

endmodule

// File: rtl/evt_save_pc.sv
// Module: evt_save_pc
// Computes the saved program counter and the delay-slot flags after entry.
// A fault in a delay slot winds the saved PC back one instruction so that the
// branch runs again, and clears all flags. The trap code moves the saved PC
// forward one instruction.
// Assumes: 2-byte instructions.
module evt_save_pc
    import evt_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ev_kind_e          kind_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [SLOT_W-1:0] flags_i,
    output logic [XLEN-1:0]   spc_o,
    output logic [SLOT_W-1:0] flags_o
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);

    logic in_slot;
    logic is_trap;

    // Purpose: detect delay-slot and trap cases
    always_comb begin
        in_slot = flags_i[SLOT_PLAIN] || flags_i[SLOT_COND];
        is_trap = (kind_i == EV_EXC) && (code_i == C_TRAP);
    end

    // Purpose: adjusted saved PC and cleared flags
    always_comb begin
        spc_o   = pc_i;
        flags_o = flags_i;
        if (in_slot) begin
            spc_o   = spc_o - INSN_BYTES;
            flags_o = '0;
        end
        if (is_trap) begin
            spc_o = spc_o + INSN_BYTES;
        end
    end

endmodule

// File: rtl/evt_entry_seq.sv
// Module: evt_entry_seq (top)
// Accepts one exception or interrupt per cycle and commits the full entry
// state switch on one clock edge: handler PC, new status word, saved copies,
// event code registers, slot flags and a one-cycle taken strobe.
// Assumes: the core presents a stable snapshot of its state each cycle and
// consumes the outputs the cycle after taken_o rises.
module evt_entry_seq
    import evt_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          LVL_W      = 4,
    parameter logic [31:0] RESET_ADDR = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic [CODE_W-1:0] irq_code_i,
    input  logic              halt_wait_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   r15_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [SLOT_W-1:0] slot_flags_i,
    output logic              taken_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o,
    output logic [SLOT_W-1:0] slot_flags_o
);

    ev_kind_e          kind;
    logic [CODE_W-1:0] eff_code;
    logic [XLEN-1:0]   tgt_pc;
    logic [XLEN-1:0]   new_sr;
    logic [XLEN-1:0]   save_pc;
    logic [SLOT_W-1:0] next_flags;
    logic              take;
    logic              chk_armed;

    evt_arbiter #(.LVL_W(LVL_W)) u_arb (
        .exc_valid_i (exc_valid_i),
        .exc_code_i  (exc_code_i),
        .irq_req_i   (irq_req_i),
        .irq_level_i (irq_level_i),
        .halt_wait_i (halt_wait_i),
        .blocked_i   (sr_i[SR_BLOCK_BIT]),
        .mask_i      (sr_i[SR_MASK_LSB +: LVL_W]),
        .kind_o      (kind),
        .exc_code_o  (eff_code)
    );

    evt_vector #(
        .XLEN       (XLEN),
        .LVL_W      (LVL_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_vec (
        .kind_i (kind),
        .code_i (eff_code),
        .vbr_i  (vbr_i),
        .sr_i   (sr_i),
        .pc_o   (tgt_pc),
        .sr_o   (new_sr)
    );

    evt_save_pc #(.XLEN(XLEN)) u_spc (
        .kind_i  (kind),
        .code_i  (eff_code),
        .pc_i    (pc_i),
        .flags_i (slot_flags_i),
        .spc_o   (save_pc),
        .flags_o (next_flags)
    );

    // Purpose: an event of either kind is accepted this cycle
    always_comb begin
        take = (kind != EV_NONE);
    end

    // Purpose: one-cycle taken strobe
    always_ff @(posedge clk) begin
        if (!rst_n) taken_o <= 1'b0;
        else        taken_o <= take;
    end

    // Purpose: commit the entry state switch only when an event is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o         <= '0;
            sr_o         <= '0;
            ssr_o        <= '0;
            spc_o        <= '0;
            sgr_o        <= '0;
            slot_flags_o <= '0;
        end else if (take) begin
            pc_o         <= tgt_pc;
            sr_o         <= new_sr;
            ssr_o        <= sr_i;
            spc_o        <= save_pc;
            sgr_o        <= r15_i;
            slot_flags_o <= next_flags;
        end
    end

    // Purpose: event code registers, each written only by its own kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expevt_o <= '0;
            intevt_o <= '0;
        end else begin
            if (kind == EV_EXC) expevt_o <= eff_code;
            if (kind == EV_IRQ) intevt_o <= irq_code_i;
        end
    end

    // Purpose: marks that a full non-reset cycle has passed, for history checks
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    // R1: an exception is always taken and never touches INTEVT
    a_r1_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |=> (taken_o && $stable(intevt_o)));

    // R3: blocked state with no halt wait lets no interrupt through
    a_r3_block_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid_i && sr_i[SR_BLOCK_BIT] && !halt_wait_i) |=> !taken_o);

    // R4: a level not above the mask is never taken
    a_r4_level_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid_i && (irq_level_i <= sr_i[SR_MASK_LSB +: LVL_W])) |=> !taken_o);

    // R5: every entry lands privileged, banked and blocked
    a_r5_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (sr_o[SR_PRIV_BIT] && sr_o[SR_BANK_BIT] && sr_o[SR_BLOCK_BIT]));

    // R11: outputs hold whenever no event was accepted
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
        !taken_o |-> ($stable(pc_o) && $stable(sr_o) && $stable(ssr_o)
                      && $stable(spc_o) && $stable(sgr_o) && $stable(slot_flags_o)));

endmodule

// File: tb/evt_entry_seq_tb.sv
// Bench for evt_entry_seq: a vector table walked by one loop, then directed
// tests for saved copies, slot flags, the strobe and reset.
module evt_entry_seq_tb;

    typedef struct packed {
        logic [23:0] tag;
        logic        exc_v;
        logic [11:0] exc_code;
        logic        irq;
        logic [3:0]  lvl;
        logic [11:0] icode;
        logic        halt;
        logic [31:0] sr;
        logic [31:0] pc;
        logic [2:0]  flags;
        logic        tk;
        logic [31:0] epc;
        logic [31:0] esr;
        logic [31:0] espc;
        logic        eint;
        logic [11:0] eevt;
    } vec_t;

    localparam logic [31:0] P   = 32'h0C00_1000;
    localparam logic [31:0] VBR = 32'h8C00_0000;
    localparam int NV = 16;

    localparam vec_t VECS [NV] = '{
        '{"R8",  1'b1, 12'h040, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_8030, P, 3'b000, 1'b1, 32'h8C00_0400, 32'h7000_8030, P, 1'b0, 12'h040},
        '{"R8",  1'b1, 12'h060, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_8030, P, 3'b000, 1'b1, 32'h8C00_0400, 32'h7000_8030, P, 1'b0, 12'h060},
        '{"R8",  1'b1, 12'h0A0, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_8030, P, 3'b000, 1'b1, 32'h8C00_0100, 32'h7000_8030, P, 1'b0, 12'h0A0},
        '{"R7",  1'b1, 12'h140, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_8030, P, 3'b000, 1'b1, 32'hA000_0000, 32'h7000_00F0, P, 1'b0, 12'h140},
        '{"R7",  1'b1, 12'h020, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_8030, P, 3'b000, 1'b1, 32'hA000_0000, 32'h7000_00F0, P, 1'b0, 12'h020},
        '{"R9",  1'b1, 12'h160, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_8030, P, 3'b000, 1'b1, 32'h8C00_0100, 32'h7000_8030, 32'h0C00_1002, 1'b0, 12'h160},
        '{"R6",  1'b1, 12'h0E0, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_8030, P, 3'b001, 1'b1, 32'h8C00_0100, 32'h7000_8030, 32'h0C00_0FFE, 1'b0, 12'h0E0},
        '{"R9",  1'b1, 12'h160, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_8030, P, 3'b010, 1'b1, 32'h8C00_0100, 32'h7000_8030, 32'h0C00_1000, 1'b0, 12'h160},
        '{"R2",  1'b1, 12'h0A0, 1'b0, 4'h0, 12'h000, 1'b0, 32'h1000_8030, P, 3'b000, 1'b1, 32'hA000_0000, 32'h7000_00F0, P, 1'b0, 12'h000},
        '{"R2",  1'b1, 12'h1E0, 1'b0, 4'h0, 12'h000, 1'b0, 32'h1000_8030, P, 3'b000, 1'b1, 32'h8C00_0100, 32'h7000_8030, P, 1'b0, 12'h1E0},
        '{"R1",  1'b1, 12'h0A0, 1'b1, 4'hF, 12'h320, 1'b0, 32'h0000_0000, P, 3'b000, 1'b1, 32'h8C00_0100, 32'h7000_0000, P, 1'b0, 12'h0A0},
        '{"R10", 1'b0, 12'h000, 1'b1, 4'h5, 12'h3A0, 1'b0, 32'h0000_0040, P, 3'b000, 1'b1, 32'h8C00_0600, 32'h7000_0040, P, 1'b1, 12'h3A0},
        '{"R4",  1'b0, 12'h000, 1'b1, 4'h4, 12'h3C0, 1'b0, 32'h0000_0040, P, 3'b000, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 12'h000},
        '{"R3",  1'b0, 12'h000, 1'b1, 4'h9, 12'h3E0, 1'b0, 32'h1000_0000, P, 3'b000, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 12'h000},
        '{"R3",  1'b0, 12'h000, 1'b1, 4'h9, 12'h5C0, 1'b1, 32'h1000_0000, P, 3'b000, 1'b1, 32'h8C00_0600, 32'h7000_0000, P, 1'b1, 12'h5C0},
        '{"R4",  1'b0, 12'h000, 1'b1, 4'h0, 12'h400, 1'b0, 32'h0000_0000, P, 3'b000, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_valid_i;
    logic [11:0] exc_code_i;
    logic        irq_req_i;
    logic [3:0]  irq_level_i;
    logic [11:0] irq_code_i;
    logic        halt_wait_i;
    logic [31:0] sr_i, pc_i, r15_i, vbr_i;
    logic [2:0]  slot_flags_i;
    logic        taken_o;
    logic [31:0] pc_o, sr_o, ssr_o, spc_o, sgr_o;
    logic [11:0] expevt_o, intevt_o;
    logic [2:0]  slot_flags_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] t_pc, t_sr, t_spc;
    logic [11:0] t_exp, t_int;

    always #5 clk = ~clk;

    evt_entry_seq u_dut (
        .clk, .rst_n, .exc_valid_i, .exc_code_i, .irq_req_i, .irq_level_i,
        .irq_code_i, .halt_wait_i, .sr_i, .pc_i, .r15_i, .vbr_i, .slot_flags_i,
        .taken_o, .pc_o, .sr_o, .ssr_o, .spc_o, .sgr_o, .expevt_o, .intevt_o,
        .slot_flags_o
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        exc_valid_i  = 1'b0;
        exc_code_i   = '0;
        irq_req_i    = 1'b0;
        irq_level_i  = '0;
        irq_code_i   = '0;
        halt_wait_i  = 1'b0;
        slot_flags_i = '0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        sr_i = '0; pc_i = '0; r15_i = '0; vbr_i = VBR;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk("R12", "taken", {31'b0, taken_o}, 32'h0);
        chk("R12", "pc", pc_o, 32'h0);
        chk("R12", "sr", sr_o, 32'h0);
        chk("R12", "expevt", {20'b0, expevt_o}, 32'h0);
        chk("R12", "intevt", {20'b0, intevt_o}, 32'h0);
        t_pc = '0; t_sr = '0; t_spc = '0; t_exp = '0; t_int = '0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tg;
            v  = VECS[i];
            tg = $sformatf("%s", v.tag);
            exc_valid_i  = v.exc_v;
            exc_code_i   = v.exc_code;
            irq_req_i    = v.irq;
            irq_level_i  = v.lvl;
            irq_code_i   = v.icode;
            halt_wait_i  = v.halt;
            sr_i         = v.sr;
            pc_i         = v.pc;
            slot_flags_i = v.flags;
            @(negedge clk);
            idle_inputs();
            if (v.tk) begin
                t_pc = v.epc; t_sr = v.esr; t_spc = v.espc;
                if (v.eint) t_int = v.eevt;
                else        t_exp = v.eevt;
            end
            chk(tg, "taken", {31'b0, taken_o}, {31'b0, v.tk});
            chk(tg, "pc", pc_o, t_pc);
            chk(tg, "sr", sr_o, t_sr);
            chk(tg, "spc", spc_o, t_spc);
            chk(tg, "expevt", {20'b0, expevt_o}, {20'b0, t_exp});
            chk(tg, "intevt", {20'b0, intevt_o}, {20'b0, t_int});
            @(negedge clk);
            // R11: strobe lasts one cycle, outputs hold when idle
            chk("R11", "taken drop", {31'b0, taken_o}, 32'h0);
            chk("R11", "pc hold", pc_o, t_pc);
        end

        // R5: saved status word and stack register
        sr_i = 32'h0000_1234; pc_i = 32'h0C00_2000; r15_i = 32'hDEAD_BEE0;
        exc_valid_i = 1'b1; exc_code_i = 12'h0A0;
        @(negedge clk);
        idle_inputs();
        chk("R5", "ssr", ssr_o, 32'h0000_1234);
        chk("R5", "sgr", sgr_o, 32'hDEAD_BEE0);
        chk("R5", "sr", sr_o, 32'h7000_1234);
        chk("R5", "spc", spc_o, 32'h0C00_2000);

        // R6: slot flags cleared when in a slot
        exc_valid_i = 1'b1; exc_code_i = 12'h0A0; slot_flags_i = 3'b101;
        @(negedge clk);
        idle_inputs();
        chk("R6", "flags in slot", {29'b0, slot_flags_o}, 32'h0);
        chk("R6", "spc in slot", spc_o, 32'h0C00_1FFE);

        // R6: flags copied when not in a slot
        exc_valid_i = 1'b1; exc_code_i = 12'h0A0; slot_flags_i = 3'b100;
        @(negedge clk);
        idle_inputs();
        chk("R6", "flags copied", {29'b0, slot_flags_o}, 32'h4);
        chk("R6", "spc no slot", spc_o, 32'h0C00_2000);

        // R11: idle cycles leave everything unchanged
        r15_i = 32'h1111_1111; sr_i = 32'h0000_00F0;
        irq_req_i = 1'b1; irq_level_i = 4'hF; irq_code_i = 12'h7E0;
        @(negedge clk);
        idle_inputs();
        chk("R11", "masked irq taken", {31'b0, taken_o}, 32'h0);
        chk("R11", "sgr hold", sgr_o, 32'hDEAD_BEE0);
        chk("R10", "intevt hold", {20'b0, intevt_o}, 32'h5C0);

        // R12: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12", "pc after reset", pc_o, 32'h0);
        chk("R12", "sgr after reset", sgr_o, 32'h0);
        chk("R12", "expevt after reset", {20'b0, expevt_o}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule